// File: doc/BRIEF.md
# Sticky-Pending Masked Interrupt Controller

This block gathers up to sixteen interrupt requests into one processor interrupt line. Each request arrives as a short high pulse on its source input. The pulse latches a pending bit in a status register. That bit holds until software acknowledges it by writing a one to the same bit position. A mask register chooses which pending bits may raise the interrupt line, which is registered.

Software reaches both registers through a simple register port. The port has separate write and read enables, one shared address and a read-valid strobe. The offsets of the status and mask registers are parameters, so instances in address maps with different register strides share the same RTL. Optional variants are chosen by parameters: each source can be edge-detected or taken as a level, and the interrupt line can be registered or combinational. The defaults are edge detection and a registered line.

Top module: `irqc_top`

## Requirements
- R1: Each of the 16 source inputs `src[i]` sets status bit i on the clock edge at which it is first sampled high after being low. Several sources may set their bits in the same cycle.
- R2: A status bit stays set after its source returns low, for any number of cycles, until software clears it.
- R3: A write to the status offset (default 0x70) clears each status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R4: A write to the mask offset (default 0x74) loads `wr_data[15:0]` into the mask in full. The mask resets to zero.
- R5: `cpu_irq` is high exactly when some bit is set in both status and mask. It follows a status or mask change one clock later. A pending bit whose mask bit is 0 leaves `cpu_irq` low.
- R6: A cleared status bit does not set again until its source goes low and then high once more. A source held high after its bit was cleared does not set the bit again.
- R7: A read returns `rd_valid` high one cycle after `rd_en`. `rd_data` then holds the addressed register as it stood when `rd_en` was sampled: status or mask in bits 15:0, with zeros above. An unmapped offset returns zero, and `rd_data` is zero whenever `rd_valid` is low.
- R8: When a source rising edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: After reset, status, mask, `cpu_irq`, `rd_valid` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | 16 | Interrupt source pulses, one bit per source |
| wr_en | input | 1 | Register write enable |
| rd_en | input | 1 | Register read enable |
| addr | input | 8 | Register byte offset, shared by reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data strobe, one cycle after `rd_en` |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The critical overlap is a source rising edge landing in the same cycle as a write-one-to-clear to the status register on that same bit. The bench forces it directly by pulsing a source while writing all ones to the status offset. It also meets the overlap many times in the random phase, where sparse source pulses fall into the same cycles as random clearing writes. The outcome is judged by a later status read and by the interrupt line, both checked against a bench model in which a new edge overrides the clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Register selected by a decoded offset
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2
   } irqc_sel_e;

   function automatic irqc_sel_e irqc_decode(input logic [15:0] a,
                                             input logic [15:0] stat_ofs,
                                             input logic [15:0] mask_ofs);
      if (a == stat_ofs)      return SEL_STAT;
      else if (a == mask_ofs) return SEL_MASK;
      else                    return SEL_NONE;
   endfunction

endpackage

// File: rtl/irqc_edge_bank.sv
module irqc_edge_bank #(
   parameter int NUM_SRC = 16,
   parameter bit EDGE    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   output logic [NUM_SRC-1:0] set
);
   generate
      if (EDGE) begin : g_edge
         logic [NUM_SRC-1:0] src_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) src_q <= '0;
            else        src_q <= src;
         end
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            assign set[i] = rst_n & src[i] & ~src_q[i];
         end
      end else begin : g_level
         assign set = rst_n ? src : '0;
      end
   endgenerate
endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
   parameter int NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] pend
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;   // new event beats a clear
            else if (clr[i]) pend[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC                 = 16,
   parameter int ADDR_W                  = 8,
   parameter int DATA_W                  = 32,
   parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
   parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NUM_SRC-1:0] pend,
   output logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] mask,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_valid
);
   irqc_sel_e sel;

   always_comb sel = irqc_decode(16'(addr), 16'(STAT_OFS), 16'(MASK_OFS));

   assign clr = (wr_en && sel == SEL_STAT) ? wr_data[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mask <= '0;
      else if (wr_en && sel == SEL_MASK) mask <= wr_data[NUM_SRC-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (!rd_en) rd_data <= '0;
         else begin
            case (sel)
               SEL_STAT: rd_data <= DATA_W'(pend);
               SEL_MASK: rd_data <= DATA_W'(mask);
               default:  rd_data <= '0;
            endcase
         end
      end
   end

   generate
      if (NUM_SRC < DATA_W) begin : g_upper
         logic unused_upper;
         assign unused_upper = ^wr_data[DATA_W-1:NUM_SRC];
      end
   endgenerate
endmodule

// File: rtl/irqc_out.sv
module irqc_out #(
   parameter int NUM_SRC = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] mask,
   output logic               irq
);
   logic hit;
   assign hit = |(pend & mask);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= hit;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = hit;
      end
   endgenerate
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int NUM_SRC                 = 16,
   parameter int ADDR_W                  = 8,
   parameter int DATA_W                  = 32,
   parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
   parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74,
   parameter bit EDGE                    = 1'b1,
   parameter bit OUT_REG                 = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_valid,
   output logic               cpu_irq
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("irqc_top: NUM_SRC must lie in 1..DATA_W");
      end
      if (STAT_OFS == MASK_OFS) begin : g_bad_ofs
         $error("irqc_top: status and mask offsets must differ");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("irqc_top: ADDR_W must lie in 1..16");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_set;
   logic [NUM_SRC-1:0] wr_clr;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask;

   irqc_edge_bank #(.NUM_SRC(NUM_SRC), .EDGE(EDGE)) u_edge (
      .clk(clk), .rst_n(rst_n), .src(src), .set(src_set)
   );

   irqc_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .set(src_set), .clr(wr_clr), .pend(pend)
   );

   irqc_regs #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .pend(pend), .clr(wr_clr), .mask(mask),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   irqc_out #(.NUM_SRC(NUM_SRC), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .irq(cpu_irq)
   );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int NUM_SRC                 = 16,
   parameter int ADDR_W                  = 8,
   parameter int DATA_W                  = 32,
   parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74,
   parameter bit OUT_REG                 = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_set,
   input logic [NUM_SRC-1:0] wr_clr,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] mask,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic               rd_valid,
   input logic               cpu_irq
);
   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(pend) & ~$past(wr_clr) & ~pend) == '0)); // R2

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend & ~$past(pend) & ~$past(src_set)) == '0)); // R6

   AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(src_set) & ~pend) == '0)); // R8

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == MASK_OFS) |=> (mask == $past(wr_data[NUM_SRC-1:0]))); // R4

   AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rd_valid == $past(rd_en))); // R7

   generate
      if (OUT_REG) begin : g_irq_reg
         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (cpu_irq == |($past(pend) & $past(mask)))); // R5
      end else begin : g_irq_comb
         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq == |(pend & mask)); // R5
      end
   endgenerate
endmodule

bind irqc_top irqc_checker #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .MASK_OFS(MASK_OFS), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_set(src_set), .wr_clr(wr_clr),
   .pend(pend), .mask(mask), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wr_data(wr_data), .rd_valid(rd_valid), .cpu_irq(cpu_irq)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
   localparam logic [7:0] STAT = 8'h70;
   localparam logic [7:0] MASK = 8'h74;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] src;
   logic        wr_en, rd_en;
   logic [7:0]  addr;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        cpu_irq;

   always #2 clk = ~clk;

   irqc_top uut (
      .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .rd_valid(rd_valid), .cpu_irq(cpu_irq)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Requirement model
   logic [15:0] m_pend = '0, m_mask = '0, m_prev = '0;

   function automatic logic [31:0] exp_read(input logic [7:0] a,
                                            input logic [15:0] p,
                                            input logic [15:0] m);
      if (a == STAT)      return {16'd0, p};
      else if (a == MASK) return {16'd0, m};
      else                return 32'd0;
   endfunction

   function automatic logic [15:0] next_pend(input logic [15:0] p,
                                             input logic [15:0] rise,
                                             input logic [15:0] clr);
      return (p & ~clr) | rise;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // One cycle: drive at a falling edge, check at the next falling edge
   task automatic step(input logic [15:0] s, input logic w, input logic r,
                       input logic [7:0] a, input logic [31:0] d,
                       input string tag);
      logic [31:0] e_rd;
      logic        e_irq;
      logic [15:0] clr;
      src = s; wr_en = w; rd_en = r; addr = a; wr_data = d;
      e_rd  = r ? exp_read(a, m_pend, m_mask) : 32'd0;
      e_irq = |(m_pend & m_mask);
      clr   = (w && a == STAT) ? d[15:0] : 16'd0;
      m_pend = next_pend(m_pend, s & ~m_prev, clr);
      if (w && a == MASK) m_mask = d[15:0];
      m_prev = s;
      @(negedge clk);
      check(tag, "cpu_irq", {31'd0, cpu_irq}, {31'd0, e_irq});
      check(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, r});
      check(tag, "rd_data", rd_data, e_rd);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; src = '0; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      check("R9", "cpu_irq in reset", {31'd0, cpu_irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      step(16'h0, 0, 1, STAT, 0, "R9");
      step(16'h0, 0, 1, MASK, 0, "R9");
      // R1: two sources pulse together
      step(16'h8001, 0, 0, 8'h00, 0, "R1");
      step(16'h0, 0, 1, STAT, 0, "R1");
      // R2: stays set over idle cycles, masked so irq stays low (R5)
      for (int i = 0; i < 6; i++) step(16'h0, 0, 0, 8'h00, 0, "R5");
      step(16'h0, 0, 1, STAT, 0, "R2");
      // R4: mask load and read back; R5: irq follows a cycle later
      step(16'h0, 1, 0, MASK, 32'hABCD_8000, "R4");
      step(16'h0, 0, 1, MASK, 0, "R4");
      step(16'h0, 0, 0, 8'h00, 0, "R5");
      // R3: write-one-to-clear only touches ones
      step(16'h0, 1, 0, STAT, 32'h0000_0001, "R3");
      step(16'h0, 0, 1, STAT, 0, "R3");
      step(16'h0, 1, 0, STAT, 32'h0000_8000, "R3");
      step(16'h0, 0, 1, STAT, 0, "R3");
      step(16'h0, 0, 0, 8'h00, 0, "R5");
      // R6: held-high source does not reassert after clear
      step(16'h0004, 0, 0, 8'h00, 0, "R6");
      step(16'h0004, 1, 0, STAT, 32'h0000_0004, "R6");
      for (int i = 0; i < 4; i++) step(16'h0004, 0, 1, STAT, 0, "R6");
      step(16'h0, 0, 1, STAT, 0, "R6");
      step(16'h0004, 0, 0, 8'h00, 0, "R6");
      step(16'h0, 0, 1, STAT, 0, "R6");
      step(16'h0, 1, 0, STAT, 32'hFFFF_FFFF, "R3");
      // R8: edge and clear in the same cycle
      step(16'h0008, 1, 0, STAT, 32'hFFFF_FFFF, "R8");
      step(16'h0, 0, 1, STAT, 0, "R8");
      step(16'h0, 1, 0, MASK, 32'h0000_0008, "R8");
      step(16'h0, 0, 0, 8'h00, 0, "R8");
      // R7: unmapped offsets, upper bits, read/write overlap
      step(16'h0, 0, 1, 8'h78, 0, "R7");
      step(16'h0, 0, 1, 8'h00, 0, "R7");
      step(16'h0, 1, 1, MASK, 32'hFFFF_0000, "R7");
      step(16'h0, 0, 1, MASK, 0, "R7");

      // Constrained random phase
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] s;
         logic [7:0]  a;
         logic [31:0] d;
         int op;
         s  = 16'($urandom & $urandom & $urandom);
         op = int'($urandom % 8);
         d  = $urandom;
         a  = 8'($urandom);
         if (a == STAT || a == MASK) a = 8'h7C;
         case (op)
            0, 1: step(s, 1, 0, STAT, d, "R3");
            2:    step(s, 1, 0, MASK, d, "R4");
            3, 4: step(s, 0, 1, STAT, d, "R7");
            5:    step(s, 0, 1, MASK, d, "R7");
            6:    step(s, 0, 1, a, d, "R7");
            default: step(s, 1, 1, STAT, d, "R8");
         endcase
      end

      done = 1;
      summary();
      $finish;
   end
endmodule